// File: doc/BRIEF.md
# Task Switch Descriptor Validator

This block decides whether the segment state that a task switch is about to load from a new task state segment is acceptable. The surrounding logic fetches the descriptors and decodes them. It then presents the limit of the incoming task state segment, the privilege level the new task will run at, and, for the local descriptor table selector and the six segment selectors (stack, code, four data), the selector value, the highest usable index of the table it points into, and the descriptor's access byte. A one-cycle start pulse captures all of these inputs.

The block then walks the checks one per clock in a fixed order: segment limit, local table, stack, code, then the four data selectors. The first check that fails ends the walk. A one-cycle done pulse carries an ok flag. On a failure it also carries a fault vector (0x0A for an invalid task state, 0x0B for a segment that is absent) and a 16-bit error code built from the offending selector. The vector and the error code stay on the outputs until the next accepted start.

Top module: `tss_load_checker`

## Requirements
- R1: While reset is held and after it is released, busy, done and ok are 0, and vector and err_code are 0.
- R2: A start seen while idle captures every input. Later input changes do not affect the result. Check k (0 = limit, 1 = local table, 2 = stack, 3 = code, 4..7 = DS, ES, FS, GS) is judged on the k+1-th rising edge after the start edge. done is high after that edge if check k fails. If all checks pass, done is high after the 8th edge. busy is high from the start edge until done.
- R3: A segment limit below 103 fails check 0 with vector 0x0A, and the error code is built from tss_sel. A limit of exactly 103 passes.
- R4: The local table selector passes if null (bits 15..2 zero). Otherwise it needs TI (bit 2) = 0, an index (bits 15..3) no larger than its bound, and an access byte with S (bit 4) = 0, type (bits 3..0) = 0010 and P (bit 7) = 1. Any violation gives 0x0A.
- R5: The stack selector fails with 0x0A if it is null, if its index exceeds its bound, or if it is not a writable data segment (S=1, type bit 3 = 0, type bit 1 = 1). It also fails with 0x0A if DPL (bits 6..5) is not equal to the new CPL, if RPL (bits 1..0) is not equal to the new CPL, or if P=0.
- R6: The code selector fails with 0x0A if it is null, out of bound, or not code (S=1 and type bit 3 = 1). Type bit 2 = 0 (nonconforming) requires DPL equal to CPL. Type bit 2 = 1 (conforming) fails if DPL is greater than CPL. A code segment that passes all of these but has P=0 gives 0x0B.
- R7: A null DS, ES, FS or GS selector passes. Otherwise the index must be within bound and the segment readable: S=1, and either data, or code with type bit 1 = 1. A violation gives 0x0A. A readable, in-bound segment with P=0 gives 0x0B.
- R8: The error code is {selector[15:3], selector[2], 1'b0, ext}. Bit 1 (the descriptor-table-for-interrupts flag) is 0. Bit 0 is the ext_event input captured at start.
- R9: When several checks would fail, the result is the one earliest in the order of R2.
- R10: A walk in which every check passes reports ok=1, vector 0 and err_code 0.
- R11: A start that arrives while busy is ignored. The walk in progress keeps its timing and its result.
- R12: done lasts exactly one cycle. ok, vector and err_code change only on the edge that raises done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk; inputs are captured on this edge |
| ext_event | input | 1 | Task switch caused by an external event; becomes error-code bit 0 |
| tss_sel | input | 16 | Selector of the incoming task state segment |
| tss_limit | input | 32 | Limit of the incoming task state segment |
| new_cpl | input | 2 | Privilege level of the new task |
| seg_sel | input | 7x16 | Selectors: [0] local table, [1] SS, [2] CS, [3] DS, [4] ES, [5] FS, [6] GS |
| seg_bound | input | 7x13 | Highest usable index of the table each selector refers to |
| seg_attr | input | 7x8 | Access byte of each descriptor: P, DPL, S, type |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | All checks passed |
| vector | output | 8 | 0x0A or 0x0B on failure, 0 on pass |
| err_code | output | 16 | Error code of the offending selector, 0 on pass |

## Verification
A step counter that is off by one, or a walk that starts from a stale position, makes done arrive on the wrong edge. The bench counts edges for every case, so such a fault shows as a latency mismatch within at most eight cycles of the start. A check that is wired to the wrong selector, or a fault class that has swapped priority, shows in the error code and the vector reported at that same done pulse. Inputs are changed mid-walk and a second start is sent mid-walk, so capture or busy-guard faults show as a changed result in the same walk.

// File: rtl/tss_chk_pkg.sv
package tss_chk_pkg;
  localparam int SEL_W  = 16;
  localparam int IDX_W  = 13;
  localparam int ATTR_W = 8;
  localparam int NSEG   = 7;
  localparam int NSTEP  = NSEG + 1;
  localparam int STEP_W = $clog2(NSTEP);

  localparam int SEG_LDT   = 0;
  localparam int SEG_STACK = 1;
  localparam int SEG_CODE  = 2;

  localparam logic [7:0] VEC_BAD_TSS     = 8'h0A;
  localparam logic [7:0] VEC_NOT_PRESENT = 8'h0B;

  typedef enum logic [1:0] {VD_OK, VD_BAD_TSS, VD_NOT_PRESENT} verdict_e;

  typedef struct packed {
    logic       present;
    logic [1:0] dpl;
    logic       user;
    logic [3:0] kind;
  } seg_attr_t;

  function automatic logic sel_is_null(logic [SEL_W-1:0] s);
    return s[SEL_W-1:2] == '0;
  endfunction

  function automatic logic in_bound(logic [SEL_W-1:0] s, logic [IDX_W-1:0] b);
    return s[SEL_W-1:3] <= b;
  endfunction

  function automatic logic is_code(seg_attr_t a);
    return a.user && a.kind[3];
  endfunction

  function automatic logic is_writable_data(seg_attr_t a);
    return a.user && !a.kind[3] && a.kind[1];
  endfunction

  function automatic logic is_readable(seg_attr_t a);
    return a.user && (!a.kind[3] || a.kind[1]);
  endfunction

  function automatic verdict_e check_ldt(logic [SEL_W-1:0] s, logic [IDX_W-1:0] b,
                                         seg_attr_t a);
    if (sel_is_null(s)) return VD_OK;
    if (s[2] || !in_bound(s, b) || a.user || a.kind != 4'b0010 || !a.present)
      return VD_BAD_TSS;
    return VD_OK;
  endfunction

  function automatic verdict_e check_stack(logic [SEL_W-1:0] s, logic [IDX_W-1:0] b,
                                           seg_attr_t a, logic [1:0] cpl);
    if (sel_is_null(s) || !in_bound(s, b) || !is_writable_data(a)) return VD_BAD_TSS;
    if (a.dpl != cpl || s[1:0] != cpl || !a.present) return VD_BAD_TSS;
    return VD_OK;
  endfunction

  function automatic verdict_e check_code(logic [SEL_W-1:0] s, logic [IDX_W-1:0] b,
                                          seg_attr_t a, logic [1:0] cpl);
    logic priv_bad;
    if (sel_is_null(s) || !in_bound(s, b) || !is_code(a)) return VD_BAD_TSS;
    priv_bad = a.kind[2] ? (a.dpl > cpl) : (a.dpl != cpl);
    if (priv_bad) return VD_BAD_TSS;
    if (!a.present) return VD_NOT_PRESENT;
    return VD_OK;
  endfunction

  function automatic verdict_e check_data(logic [SEL_W-1:0] s, logic [IDX_W-1:0] b,
                                          seg_attr_t a);
    if (sel_is_null(s)) return VD_OK;
    if (!in_bound(s, b) || !is_readable(a)) return VD_BAD_TSS;
    if (!a.present) return VD_NOT_PRESENT;
    return VD_OK;
  endfunction

  function automatic logic [SEL_W-1:0] err_fmt(logic [SEL_W-1:0] s, logic ext);
    return {s[SEL_W-1:3], s[2], 1'b0, ext};
  endfunction

  function automatic logic [7:0] vector_of(verdict_e v);
    case (v)
      VD_BAD_TSS:     return VEC_BAD_TSS;
      VD_NOT_PRESENT: return VEC_NOT_PRESENT;
      default:        return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/tss_seg_rules.sv
module tss_seg_rules
  import tss_chk_pkg::*;
#(
  parameter int LIMIT_W   = 32,
  parameter int MIN_LIMIT = 103
) (
  input  logic [STEP_W-1:0]             step,
  input  logic [LIMIT_W-1:0]            tss_limit,
  input  logic [SEL_W-1:0]              tss_sel,
  input  logic [1:0]                    cpl,
  input  logic [NSEG-1:0][SEL_W-1:0]    sel,
  input  logic [NSEG-1:0][IDX_W-1:0]    bound,
  input  logic [NSEG-1:0][ATTR_W-1:0]   attr,
  output verdict_e                      verdict,
  output logic [SEL_W-1:0]              culprit
);
  verdict_e seg_vd [NSEG];
  logic limit_short;
  logic [STEP_W-1:0] seg_pick;

  assign limit_short = tss_limit < LIMIT_W'(MIN_LIMIT);
  assign seg_pick    = step - 1'b1;

  for (genvar gi = 0; gi < NSEG; gi++) begin : g_seg
    if (gi == SEG_LDT) begin : g_ldt
      assign seg_vd[gi] = check_ldt(sel[gi], bound[gi], seg_attr_t'(attr[gi]));
    end else if (gi == SEG_STACK) begin : g_stack
      assign seg_vd[gi] = check_stack(sel[gi], bound[gi], seg_attr_t'(attr[gi]), cpl);
    end else if (gi == SEG_CODE) begin : g_code
      assign seg_vd[gi] = check_code(sel[gi], bound[gi], seg_attr_t'(attr[gi]), cpl);
    end else begin : g_data
      assign seg_vd[gi] = check_data(sel[gi], bound[gi], seg_attr_t'(attr[gi]));
    end
  end

  always_comb begin
    verdict = VD_OK;
    culprit = tss_sel;
    if (step == '0) begin
      verdict = limit_short ? VD_BAD_TSS : VD_OK;
    end else if (int'(seg_pick) < NSEG) begin
      verdict = seg_vd[seg_pick];
      culprit = sel[seg_pick];
    end
  end
endmodule

// File: rtl/tss_walk_ctrl.sv
module tss_walk_ctrl
  import tss_chk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              step_fail,
  output logic              busy,
  output logic              accept,
  output logic              finish,
  output logic [STEP_W-1:0] step,
  output logic              done
);
  logic walk_last;

  assign accept    = start && !busy;
  assign walk_last = (step == STEP_W'(NSTEP - 1));
  assign finish    = busy && (step_fail || walk_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      step <= '0;
      done <= 1'b0;
    end else begin
      done <= finish;
      if (accept) begin
        busy <= 1'b1;
        step <= '0;
      end else if (finish) begin
        busy <= 1'b0;
      end else if (busy) begin
        step <= step + 1'b1;
      end
    end
  end

  a_r2_accept_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy && step == '0);
  a_r11_step_advances: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !finish |=> busy && step == $past(step) + 1'b1);
  a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r2_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));
endmodule

// File: rtl/tss_load_checker.sv
module tss_load_checker
  import tss_chk_pkg::*;
#(
  parameter int LIMIT_W   = 32,
  parameter int MIN_LIMIT = 103
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          ext_event,
  input  logic [SEL_W-1:0]              tss_sel,
  input  logic [LIMIT_W-1:0]            tss_limit,
  input  logic [1:0]                    new_cpl,
  input  logic [NSEG-1:0][SEL_W-1:0]    seg_sel,
  input  logic [NSEG-1:0][IDX_W-1:0]    seg_bound,
  input  logic [NSEG-1:0][ATTR_W-1:0]   seg_attr,
  output logic                          busy,
  output logic                          done,
  output logic                          ok,
  output logic [7:0]                    vector,
  output logic [SEL_W-1:0]              err_code
);
  logic [SEL_W-1:0]             tss_sel_q;
  logic [LIMIT_W-1:0]           limit_q;
  logic [1:0]                   cpl_q;
  logic                         ext_q;
  logic [NSEG-1:0][SEL_W-1:0]   sel_q;
  logic [NSEG-1:0][IDX_W-1:0]   bound_q;
  logic [NSEG-1:0][ATTR_W-1:0]  attr_q;

  logic              accept, finish, step_fail;
  logic [STEP_W-1:0] step;
  verdict_e          verdict;
  logic [SEL_W-1:0]  culprit;

  assign step_fail = busy && (verdict != VD_OK);

  tss_walk_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .step_fail (step_fail),
    .busy      (busy),
    .accept    (accept),
    .finish    (finish),
    .step      (step),
    .done      (done)
  );

  tss_seg_rules #(.LIMIT_W(LIMIT_W), .MIN_LIMIT(MIN_LIMIT)) u_rules (
    .step      (step),
    .tss_limit (limit_q),
    .tss_sel   (tss_sel_q),
    .cpl       (cpl_q),
    .sel       (sel_q),
    .bound     (bound_q),
    .attr      (attr_q),
    .verdict   (verdict),
    .culprit   (culprit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tss_sel_q <= '0;
      limit_q   <= '0;
      cpl_q     <= '0;
      ext_q     <= 1'b0;
      sel_q     <= '0;
      bound_q   <= '0;
      attr_q    <= '0;
    end else if (accept) begin
      tss_sel_q <= tss_sel;
      limit_q   <= tss_limit;
      cpl_q     <= new_cpl;
      ext_q     <= ext_event;
      sel_q     <= seg_sel;
      bound_q   <= seg_bound;
      attr_q    <= seg_attr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ok       <= 1'b0;
      vector   <= '0;
      err_code <= '0;
    end else if (finish) begin
      ok       <= (verdict == VD_OK);
      vector   <= vector_of(verdict);
      err_code <= (verdict == VD_OK) ? '0 : err_fmt(culprit, ext_q);
    end
  end

  a_r10_pass_clean: assert property (@(posedge clk) disable iff (!rst_n)
    done && ok |-> vector == 8'h00 && err_code == '0);
  a_r3_vector_legal: assert property (@(posedge clk) disable iff (!rst_n)
    done && !ok |-> vector == VEC_BAD_TSS || vector == VEC_NOT_PRESENT);
  a_r8_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    done && !ok |-> err_code[1] == 1'b0 && err_code[0] == ext_q);
  a_r12_results_held: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(finish) |-> $stable(vector) && $stable(err_code) && $stable(ok));
  a_r6_absent_only_late: assert property (@(posedge clk) disable iff (!rst_n)
    finish && verdict == VD_NOT_PRESENT |-> step >= STEP_W'(SEG_CODE + 1));
endmodule

// File: tb/tss_load_checker_bench.sv
module tss_load_checker_bench;
  import tss_chk_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                        rst_n, start, ext_event;
  logic [15:0]                 tss_sel;
  logic [31:0]                 tss_limit;
  logic [1:0]                  new_cpl;
  logic [NSEG-1:0][15:0]       seg_sel;
  logic [NSEG-1:0][12:0]       seg_bound;
  logic [NSEG-1:0][7:0]        seg_attr;
  logic                        busy, done, ok;
  logic [7:0]                  vector;
  logic [15:0]                 err_code;

  int n_run = 0;
  int n_fail = 0;

  tss_load_checker u_tss_load_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .ext_event(ext_event),
    .tss_sel(tss_sel), .tss_limit(tss_limit), .new_cpl(new_cpl),
    .seg_sel(seg_sel), .seg_bound(seg_bound), .seg_attr(seg_attr),
    .busy(busy), .done(done), .ok(ok), .vector(vector), .err_code(err_code)
  );

  task automatic check(bit cond, string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ec(logic [15:0] s, logic x);
    return {s[15:3], s[2], 1'b0, x};
  endfunction

  task automatic set_base();
    ext_event = 1'b0;
    tss_sel   = 16'h0028;
    tss_limit = 32'd103;
    new_cpl   = 2'd3;
    seg_bound = '0;
    for (int i = 0; i < NSEG; i++) seg_bound[i] = 13'd100;
    seg_sel[0] = 16'h0030; seg_attr[0] = 8'h82;
    seg_sel[1] = 16'h0013; seg_attr[1] = 8'hF2;
    seg_sel[2] = 16'h001B; seg_attr[2] = 8'hFA;
    seg_sel[3] = 16'h0023; seg_attr[3] = 8'hF2;
    seg_sel[4] = 16'h0000; seg_attr[4] = 8'h00;
    seg_sel[5] = 16'h002B; seg_attr[5] = 8'hF0;
    seg_sel[6] = 16'h0037; seg_attr[6] = 8'hF2;
  endtask

  task automatic walk(string tag, int exp_lat, bit exp_ok, logic [7:0] exp_vec,
                      logic [15:0] exp_err);
    int lat = 0;
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    check(busy === 1'b1, {tag, " R2 busy after start"}, 32'(busy), 1);
    while (!done && lat < 20) begin
      @(posedge clk); lat++;
      @(negedge clk);
    end
    check(lat == exp_lat, {tag, " R2 latency"}, lat, exp_lat);
    check(ok === exp_ok, {tag, " ok"}, 32'(ok), 32'(exp_ok));
    check(vector === exp_vec, {tag, " vector"}, vector, exp_vec);
    check(err_code === exp_err, {tag, " R8 err_code"}, err_code, exp_err);
    @(negedge clk);
    check(done === 1'b0, {tag, " R12 done one cycle"}, 32'(done), 0);
    check(vector === exp_vec && err_code === exp_err, {tag, " R12 held"},
          {vector, 8'h00, err_code}, {exp_vec, 8'h00, exp_err});
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; set_base();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!busy && !done && !ok, "R1 flags in reset", {busy, done, ok}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(vector == 0 && err_code == 0, "R1 outputs after reset", {vector, err_code}, 0);
  endtask

  task automatic t_pass();
    set_base(); walk("R10 all pass", 8, 1, 8'h00, 16'h0000);
    set_base(); seg_sel[0] = 16'h0000; seg_attr[0] = 8'h00;
    walk("R4 null local table", 8, 1, 8'h00, 16'h0000);
    set_base(); seg_attr[2] = 8'h9E;
    walk("R6 conforming lower dpl", 8, 1, 8'h00, 16'h0000);
    set_base(); seg_attr[5] = 8'hFA;
    walk("R7 readable code in FS", 8, 1, 8'h00, 16'h0000);
  endtask

  task automatic t_limit();
    set_base(); tss_limit = 32'd102; ext_event = 1'b1;
    walk("R3 short limit", 1, 0, 8'h0A, ec(16'h0028, 1'b1));
  endtask

  task automatic t_ldt();
    set_base(); seg_attr[0] = 8'h02;
    walk("R4 absent local table", 2, 0, 8'h0A, ec(16'h0030, 1'b0));
    set_base(); seg_sel[0] = 16'h0034;
    walk("R4 local table TI set", 2, 0, 8'h0A, ec(16'h0034, 1'b0));
    set_base(); seg_attr[0] = 8'h92;
    walk("R4 local table not system", 2, 0, 8'h0A, ec(16'h0030, 1'b0));
  endtask

  task automatic t_stack();
    set_base(); seg_sel[1] = 16'h0012;
    walk("R5 stack rpl", 3, 0, 8'h0A, ec(16'h0012, 1'b0));
    set_base(); seg_attr[1] = 8'hD2;
    walk("R5 stack dpl", 3, 0, 8'h0A, ec(16'h0013, 1'b0));
    set_base(); seg_attr[1] = 8'hF0;
    walk("R5 stack read only", 3, 0, 8'h0A, ec(16'h0013, 1'b0));
    set_base(); seg_bound[1] = 13'd1;
    walk("R5 stack out of bound", 3, 0, 8'h0A, ec(16'h0013, 1'b0));
    set_base(); seg_attr[1] = 8'h72;
    walk("R5 stack absent", 3, 0, 8'h0A, ec(16'h0013, 1'b0));
  endtask

  task automatic t_code();
    set_base(); seg_attr[2] = 8'hF2;
    walk("R6 data as code", 4, 0, 8'h0A, ec(16'h001B, 1'b0));
    set_base(); seg_attr[2] = 8'hDA;
    walk("R6 nonconforming dpl", 4, 0, 8'h0A, ec(16'h001B, 1'b0));
    set_base(); new_cpl = 2'd1; seg_sel[1] = 16'h0011; seg_attr[1] = 8'hB2;
    seg_sel[2] = 16'h0019; seg_attr[2] = 8'hDE;
    walk("R6 conforming dpl above cpl", 4, 0, 8'h0A, ec(16'h0019, 1'b0));
    set_base(); seg_attr[2] = 8'h7A;
    walk("R6 code absent", 4, 0, 8'h0B, ec(16'h001B, 1'b0));
  endtask

  task automatic t_data();
    set_base(); seg_attr[3] = 8'h72;
    walk("R7 DS absent", 5, 0, 8'h0B, ec(16'h0023, 1'b0));
    set_base(); seg_attr[5] = 8'hF8;
    walk("R7 FS execute only", 7, 0, 8'h0A, ec(16'h002B, 1'b0));
    set_base(); seg_attr[6] = 8'hE2; ext_event = 1'b1;
    walk("R7 GS system", 8, 0, 8'h0A, ec(16'h0037, 1'b1));
    set_base(); seg_bound[6] = 13'd5;
    walk("R7 GS out of bound", 8, 0, 8'h0A, ec(16'h0037, 1'b0));
  endtask

  task automatic t_order();
    set_base(); seg_sel[1] = 16'h0012; seg_attr[3] = 8'h72;
    walk("R9 stack before DS", 3, 0, 8'h0A, ec(16'h0012, 1'b0));
    set_base(); seg_attr[3] = 8'h72; seg_attr[6] = 8'hE2;
    walk("R9 DS before GS", 5, 0, 8'h0B, ec(16'h0023, 1'b0));
  endtask

  task automatic t_restart_ignored();
    int lat = 0;
    set_base();
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    seg_attr[3] = 8'h72;
    while (!done && lat < 20) begin
      @(posedge clk); lat++;
      @(negedge clk);
      start = (lat == 2);
      if (lat == 2) seg_attr[1] = 8'hD2;
    end
    start = 1'b0;
    check(lat == 8, "R11 restart ignored latency", lat, 8);
    check(ok === 1'b1, "R2 R11 result from captured inputs", 32'(ok), 1);
    check(vector === 8'h00, "R11 vector", vector, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_pass();
    t_limit();
    t_ldt();
    t_stack();
    t_code();
    t_data();
    t_order();
    t_restart_ignored();
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule